// File: doc/BRIEF.md
# PLL Factor Solver

This block turns a requested synthesizer frequency into the four factor fields of a PLL whose reference is fixed at 24 MHz. The loop produces `ref * N * (K+1)`, a power-of-two post-divider shifts that right by `P`, and a final divider takes `M+1`. The request arrives as a count of 6 MHz steps. A caller that holds a frequency in hertz first divides it by 6 MHz, which rounds it down to a whole step. The solver then returns N, K, M, P and the frequency those factors actually give, also counted in 6 MHz steps.

The factors are not found by a best-fit search. P and K come from fixed rules on the range and the low bits of the step count, and N follows from them by shift and division. The datapath has two register stages. Stage one captures the request and classifies it into K and P. Stage two derives N and the achieved rate, then raises a one-cycle done strobe. A new request may be issued every cycle.

Top module: `pll_factor_solver`

## Requirements
- R1: The achieved rate equals floor(4 * N * (K+1) / 2^P) in 6 MHz steps. It never exceeds the requested step count.
- R2: The M field is always zero.
- R3: K is 1 when the step count is 128 or more, or is exactly 7 or 9. For every other count K is 0.
- R4: P is 3 for any step count below 10.
- R5: P is 2 for step counts from 10 to 19, and for odd step counts from 21 to 31.
- R6: P is 1 for step counts from 20 to 39 not already covered by R5, and for counts from 40 to 63 with bit 1 set. P is 0 for all other counts.
- R7: N equals floor(floor(steps * 2^P / (K+1)) / 4), and it fits in 5 bits.
- R8: `done_o` rises on the second rising edge after the edge that samples `start_i`, and it stays high for one cycle per request. Requests on consecutive cycles each produce their own result, in order.
- R9: The result outputs change only in a cycle where `done_o` is high. Between results they hold their value.
- R10: A step count of zero yields N = 0, K = 0, M = 0 and an achieved rate of 0.
- R11: While reset is asserted, `done_o` is low and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled on each rising edge |
| steps_i | input | 8 | Requested frequency in 6 MHz steps |
| done_o | output | 1 | One-cycle strobe marking a new result |
| n_o | output | 5 | Loop multiplier N |
| k_o | output | 2 | Secondary multiplier K (applied as K+1) |
| m_o | output | 2 | Final divider M (applied as M+1) |
| p_o | output | 2 | Post-divider shift P |
| ach_o | output | 8 | Achieved frequency in 6 MHz steps |

## Verification
The properties assume that `steps_i` is valid in every cycle where `start_i` is high. Two cycles later they compare it, through `$past`, with the result marked by `done_o`. They also assume that `start_i` is never driven unknown once reset is released. The stimulus changes `start_i` and `steps_i` only on falling edges. It covers every step value from 0 to 255, both back to back and with idle gaps. After the final result it holds `start_i` low, so the hold property can be seen over an idle stretch.

// File: rtl/pllfs_pkg.sv
package pllfs_pkg;
  // Field and datapath widths
  localparam int STEP_W = 8;
  localparam int N_W    = 5;
  localparam int K_W    = 2;
  localparam int M_W    = 2;
  localparam int P_W    = 2;
  localparam int WORK_W = STEP_W + 2;  // room for the left shift by P

  // Range limits of the post-divider rules
  localparam logic [STEP_W-1:0] P3_BELOW     = STEP_W'(10);
  localparam logic [STEP_W-1:0] P2_BELOW     = STEP_W'(20);
  localparam logic [STEP_W-1:0] P2_ODD_BELOW = STEP_W'(32);
  localparam logic [STEP_W-1:0] P1_BELOW     = STEP_W'(40);
  localparam logic [STEP_W-1:0] P1_BIT_BELOW = STEP_W'(64);

  // K is selected when the count reaches this value or matches one of two exceptions
  localparam logic [STEP_W-1:0] K_HIGH_FROM  = STEP_W'(128);
  localparam logic [STEP_W-1:0] K_EXCEPT_LO  = STEP_W'(7);
  localparam logic [STEP_W-1:0] K_EXCEPT_HI  = STEP_W'(9);

  function automatic logic [K_W-1:0] pick_k(input logic [STEP_W-1:0] s);
    logic hit;
    hit = (s >= K_HIGH_FROM) || (s == K_EXCEPT_LO) || (s == K_EXCEPT_HI);
    return hit ? K_W'(1) : K_W'(0);
  endfunction

  function automatic logic [P_W-1:0] pick_p(input logic [STEP_W-1:0] s);
    logic [P_W-1:0] r;
    if (s < P3_BELOW)
      r = P_W'(3);
    else if ((s < P2_BELOW) || ((s < P2_ODD_BELOW) && s[0]))
      r = P_W'(2);
    else if ((s < P1_BELOW) || ((s < P1_BIT_BELOW) && s[1]))
      r = P_W'(1);
    else
      r = P_W'(0);
    return r;
  endfunction

  // N = ((s << p) / (k+1)) / 4
  function automatic logic [N_W-1:0] calc_n(input logic [STEP_W-1:0] s,
                                            input logic [K_W-1:0]    k,
                                            input logic [P_W-1:0]    p);
    logic [WORK_W-1:0] shifted;
    logic [WORK_W-1:0] divisor;
    logic [WORK_W-1:0] quot;
    shifted = WORK_W'(s) << p;
    divisor = WORK_W'(k) + WORK_W'(1);
    quot    = (shifted / divisor) >> 2;
    return quot[N_W-1:0];
  endfunction

  // achieved steps = (4 * n * (k+1)) >> p
  function automatic logic [STEP_W-1:0] calc_ach(input logic [N_W-1:0] n,
                                                 input logic [K_W-1:0] k,
                                                 input logic [P_W-1:0] p);
    logic [WORK_W-1:0] prod;
    prod = (WORK_W'(n) * (WORK_W'(k) + WORK_W'(1))) << 2;
    prod = prod >> p;
    return prod[STEP_W-1:0];
  endfunction
endpackage

// File: rtl/pllfs_classify.sv
// Stage one: capture the request and select K and P.
module pllfs_classify
  import pllfs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] steps_i,
  output logic              vld_o,
  output logic [STEP_W-1:0] steps_o,
  output logic [K_W-1:0]    k_o,
  output logic [P_W-1:0]    p_o
);
  logic [K_W-1:0] k_next;
  logic [P_W-1:0] p_next;

  always_comb begin
    k_next = pick_k(steps_i);
    p_next = pick_p(steps_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      steps_o <= '0;
      k_o     <= '0;
      p_o     <= '0;
    end else begin
      vld_o <= start_i;
      if (start_i) begin
        steps_o <= steps_i;
        k_o     <= k_next;
        p_o     <= p_next;
      end
    end
  end
endmodule

// File: rtl/pllfs_factor.sv
// Stage two: derive N and the achieved rate, register the result.
module pllfs_factor
  import pllfs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic [K_W-1:0]    k_i,
  input  logic [P_W-1:0]    p_i,
  output logic              done_o,
  output logic [N_W-1:0]    n_o,
  output logic [K_W-1:0]    k_o,
  output logic [P_W-1:0]    p_o,
  output logic [STEP_W-1:0] ach_o
);
  logic [N_W-1:0]    n_next;
  logic [STEP_W-1:0] ach_next;

  always_comb begin
    n_next   = calc_n(steps_i, k_i, p_i);
    ach_next = calc_ach(n_next, k_i, p_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      n_o    <= '0;
      k_o    <= '0;
      p_o    <= '0;
      ach_o  <= '0;
    end else begin
      done_o <= vld_i;
      if (vld_i) begin
        n_o   <= n_next;
        k_o   <= k_i;
        p_o   <= p_i;
        ach_o <= ach_next;
      end
    end
  end
endmodule

// File: rtl/pll_factor_solver.sv
module pll_factor_solver
  import pllfs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] steps_i,
  output logic              done_o,
  output logic [N_W-1:0]    n_o,
  output logic [K_W-1:0]    k_o,
  output logic [M_W-1:0]    m_o,
  output logic [P_W-1:0]    p_o,
  output logic [STEP_W-1:0] ach_o
);
  // Named inter-stage events, visible to the checker
  logic              s1_vld;
  logic [STEP_W-1:0] s1_steps;
  logic [K_W-1:0]    s1_k;
  logic [P_W-1:0]    s1_p;

  pllfs_classify u_classify (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .steps_i (steps_i),
    .vld_o   (s1_vld),
    .steps_o (s1_steps),
    .k_o     (s1_k),
    .p_o     (s1_p)
  );

  pllfs_factor u_factor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s1_vld),
    .steps_i (s1_steps),
    .k_i     (s1_k),
    .p_i     (s1_p),
    .done_o  (done_o),
    .n_o     (n_o),
    .k_o     (k_o),
    .p_o     (p_o),
    .ach_o   (ach_o)
  );

  // This loop type never uses its final divider
  assign m_o = '0;
endmodule

// File: rtl/pll_factor_solver_chk.sv
module pll_factor_solver_chk
  import pllfs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [STEP_W-1:0] steps_i,
  input logic              done_o,
  input logic [N_W-1:0]    n_o,
  input logic [K_W-1:0]    k_o,
  input logic [M_W-1:0]    m_o,
  input logic [P_W-1:0]    p_o,
  input logic [STEP_W-1:0] ach_o,
  input logic              s1_vld,
  input logic [P_W-1:0]    s1_p
);
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 done_o); // R8

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2)); // R8

  AST_STAGE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld |=> (done_o && p_o == $past(s1_p))); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({n_o, k_o, m_o, p_o, ach_o})); // R9

  AST_ACH_NOT_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ach_o <= $past(steps_i, 2))); // R1

  AST_K_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(steps_i, 2) >= K_HIGH_FROM) |-> (k_o == K_W'(1))); // R3

  AST_P_LOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(steps_i, 2) < P3_BELOW) |-> (p_o == P_W'(3))); // R4

  AST_ZERO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(steps_i, 2) == '0) |-> (n_o == '0 && ach_o == '0)); // R10
endmodule

bind pll_factor_solver pll_factor_solver_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .steps_i (steps_i),
  .done_o  (done_o),
  .n_o     (n_o),
  .k_o     (k_o),
  .m_o     (m_o),
  .p_o     (p_o),
  .ach_o   (ach_o),
  .s1_vld  (s1_vld),
  .s1_p    (s1_p)
);

// File: tb/pll_factor_solver_tb.sv
module pll_factor_solver_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] steps_i = '0;
  logic       done_o;
  logic [4:0] n_o;
  logic [1:0] k_o;
  logic [1:0] m_o;
  logic [1:0] p_o;
  logic [7:0] ach_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  pll_factor_solver u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .steps_i(steps_i),
    .done_o(done_o), .n_o(n_o), .k_o(k_o), .m_o(m_o), .p_o(p_o), .ach_o(ach_o)
  );

  typedef struct packed {
    logic [7:0] s;
    logic [4:0] n;
    logic [1:0] k;
    logic [1:0] p;
    logic [7:0] ach;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 0;

  // Reference model written from the requirements
  function automatic exp_t model(input int s);
    exp_t e;
    int k, p, n, a;
    k = (s >= 128 || s == 7 || s == 9) ? 1 : 0;      // R3
    if (s >= 64)      p = 0;                          // R6
    else if (s >= 40) p = ((s / 2) % 2 == 1) ? 1 : 0; // R6
    else if (s >= 32) p = 1;                          // R6
    else if (s >= 20) p = (s % 2 == 1) ? 2 : 1;       // R5, R6
    else if (s >= 10) p = 2;                          // R5
    else              p = 3;                          // R4
    n = (s * (1 << p)) / (4 * (k + 1));               // R7
    a = (4 * n * (k + 1)) / (1 << p);                 // R1
    e.s = 8'(s); e.n = 5'(n); e.k = 2'(k); e.p = 2'(p); e.ach = 8'(a);
    return e;
  endfunction

  function automatic string p_tag(input int s);
    if (s < 10) return "R4";
    if (s < 20 || (s < 32 && s % 2 == 1)) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: issue one request and record its expected result
  task automatic send(input int s);
    @(negedge clk_i);
    start_i = 1'b1;
    steps_i = 8'(s);
    exp_q.push_back(model(s));
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      start_i = 1'b0;
    end
  endtask

  // Monitor: compare every result against the front of the queue
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        check("R8", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        last_exp = e;
        check("R7", $sformatf("N for %0d", e.s), n_o, e.n);
        check("R3", $sformatf("K for %0d", e.s), k_o, e.k);
        check("R2", $sformatf("M for %0d", e.s), m_o, 0);
        check(p_tag(e.s), $sformatf("P for %0d", e.s), p_o, e.p);
        check("R1", $sformatf("ach for %0d", e.s), ach_o, e.ach);
        if (e.s == 0)
          check("R10", "zero request all-zero", {n_o, k_o, m_o, ach_o}, 0);
      end
    end
  end

  initial begin
    int directed[] = '{0, 1, 5, 7, 8, 9, 10, 19, 20, 21, 22, 31, 32, 33, 39,
                       40, 41, 42, 63, 64, 66, 127, 128, 130, 255};
    // R11: reset state
    repeat (3) @(negedge clk_i);
    check("R11", "done in reset", done_o, 0);
    check("R11", "outputs in reset", {n_o, k_o, m_o, p_o, ach_o}, 0);
    rst_ni = 1'b1;
    idle(2);

    // Spaced requests at the rule boundaries
    foreach (directed[i]) begin
      send(directed[i]);
      idle(3);
    end

    // R8: latency of a single request
    send(22);
    idle(1);
    check("R8", "done one cycle after start edge", done_o, 0);
    @(negedge clk_i);
    check("R8", "done two cycles after start edge", done_o, 1);
    @(negedge clk_i);
    check("R8", "done is a single pulse", done_o, 0);
    idle(2);

    // Back-to-back sweep of every value (R8 ordering)
    for (int s = 0; s < 256; s++) send(s);
    idle(4);
    check("R8", "all results returned", exp_q.size(), 0);

    // R9: outputs hold with no request
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      check("R9", "n held", n_o, last_exp.n);
      check("R9", "ach held", ach_o, last_exp.ach);
      check("R9", "done stays low", done_o, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule